// File: doc/BRIEF.md
# Virtqueue Common Configuration Register Block

This block holds the driver-visible common configuration of a paravirtual device: a status byte, a configuration generation count, two feature page selectors, a configuration interrupt vector, a queue selector and an array of per-queue state. Each queue slot carries a ring size, an interrupt vector, a ready flag and three 64-bit ring base addresses (descriptor, available, used). The driver reaches one slot at a time: the queue selector picks which slot shows through the per-queue window.

Requests arrive as single beats with an offset, a byte count of 1, 2, 4 or 8, a write flag and little-endian data. A register is found by its offset and its access width together, so the same offset can be mapped at one width and unmapped at another. The request channel has a valid pin only: every beat is taken on the clock edge where `req_valid` is high, and the block never applies back-pressure. Each read produces exactly one response beat one cycle later, which the consumer must take at once because the response cannot be stalled. Feature acknowledgements from the driver appear on a single-cycle strobe with a 64-bit mask. The ring engines read each queue's programmed state from the flattened per-queue outputs.

Top module: `vq_common_regs`

## Requirements
- R1: After reset every register reads zero, every queue is not ready, and `rsp_valid`, `wr_err` and `ack_valid` are low.
- R2: A byte write at 0x14 sets the device status, which a byte read at 0x14 returns; a byte read at 0x15 returns the configuration generation (zero from reset), and a byte write at 0x15 changes nothing and raises `wr_err`.
- R3: Word access at 0x10 reads and writes the configuration vector and at 0x16 the queue selector; a word read at 0x12 returns the queue count parameter and at 0x1E returns the current queue selector; word writes to 0x12 and 0x1E raise `wr_err`.
- R4: Word access at 0x18 and 0x1A reads and writes the size and the vector of the selected queue; a size above the queue size limit parameter is stored as the limit.
- R5: A word write at 0x1C makes the selected queue ready when the value is exactly 1 and not ready for any other value; a word read at 0x1C returns 1 or 0 accordingly.
- R6: Dword access at 0x00 and 0x08 reads and writes the device and driver feature page selectors; a dword read at 0x04 returns bits 31:0 of `dev_features` for selector 0, bits 63:32 for selector 1 and zero otherwise; a dword write at 0x04 raises `wr_err`.
- R7: A dword write at 0x0C with driver selector 0 or 1 pulses `ack_valid` in the same cycle with `ack_mask` equal to the 32-bit value shifted left by 32 times the selector; with a selector of 2 or more no pulse and no error occur.
- R8: Dword writes at 0x20/0x28/0x30 replace bits 31:0, and at 0x24/0x2C/0x34 bits 63:32, of the selected queue's descriptor, available and used ring address; the other half is kept.
- R9: Qword writes at 0x20, 0x28 and 0x30 replace the whole descriptor, available and used ring address; every qword read returns zero.
- R10: With the queue selector at or beyond the queue count, per-queue reads return zero and per-queue writes change no queue state and raise no error.
- R11: Reads at offsets unmapped for their width return zero; writes there raise `wr_err` for one cycle, in the cycle after the write, and change no state.
- R12: An access whose byte count is not 1, 2, 4 or 8 changes no state, raises no error and, for a read, returns zero.
- R13: Every read request yields exactly one `rsp_valid` beat in the following cycle, and `rsp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present, always accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | OFS_W | Register byte offset |
| req_size | input | 4 | Access byte count |
| req_wdata | input | 64 | Write data, little-endian, low bytes used |
| rsp_valid | output | 1 | Read data present, one cycle after the read |
| rsp_rdata | output | 64 | Read data, zero-extended |
| wr_err | output | 1 | One-cycle flag for a rejected write |
| dev_features | input | 64 | Device feature vector |
| ack_valid | output | 1 | Driver feature acknowledge strobe |
| ack_mask | output | 64 | Acknowledged feature mask |
| q_ready | output | NQ | Ready flag per queue |
| q_size_o | output | NQ*16 | Ring size per queue, slot i at bits 16i+15:16i |
| q_vector_o | output | NQ*16 | Interrupt vector per queue |
| q_desc_o | output | NQ*64 | Descriptor ring address per queue |
| q_avail_o | output | NQ*64 | Available ring address per queue |
| q_used_o | output | NQ*64 | Used ring address per queue |

## Verification
The properties take for granted that the request inputs are settled and known at every clock edge after reset, and that a beat with `req_valid` high is a complete request, since nothing holds or retries it. They also rely on `dev_features` being steady while a feature read is in flight. The bench drives every request in the half cycle away from the sampling edge, holds it for exactly one edge and leaves the bus idle between beats, so each response and error flag can be matched to a single request.

// File: rtl/vq_pkg.sv
package vq_pkg;

  // write actions produced by the width/offset decoder
  typedef enum logic [3:0] {
    OP_NONE,
    OP_STATUS,
    OP_MSIX,
    OP_QSEL,
    OP_QSIZE,
    OP_QVEC,
    OP_QEN,
    OP_DFSEL,
    OP_GFSEL,
    OP_GFEAT,
    OP_ADDR_LO,
    OP_ADDR_HI,
    OP_ADDR_FULL,
    OP_BAD
  } wop_e;

  // which ring base an address write targets
  typedef enum logic [1:0] {
    RING_DESC,
    RING_AVAIL,
    RING_USED,
    RING_NONE
  } ring_e;

  // read sources
  typedef enum logic [3:0] {
    RD_ZERO,
    RD_STATUS,
    RD_GEN,
    RD_MSIX,
    RD_NQ,
    RD_QSEL,
    RD_QSIZE,
    RD_QVEC,
    RD_QEN,
    RD_DFSEL,
    RD_DFEAT,
    RD_GFSEL
  } rop_e;

  // byte-wide offsets
  localparam int unsigned OFS_STATUS   = 'h14;
  localparam int unsigned OFS_GEN      = 'h15;
  // word-wide offsets
  localparam int unsigned OFS_MSIX     = 'h10;
  localparam int unsigned OFS_NQ       = 'h12;
  localparam int unsigned OFS_QSEL     = 'h16;
  localparam int unsigned OFS_QSIZE    = 'h18;
  localparam int unsigned OFS_QVEC     = 'h1A;
  localparam int unsigned OFS_QEN      = 'h1C;
  localparam int unsigned OFS_QNOTIFY  = 'h1E;
  // dword-wide offsets
  localparam int unsigned OFS_DFSEL    = 'h00;
  localparam int unsigned OFS_DFEAT    = 'h04;
  localparam int unsigned OFS_GFSEL    = 'h08;
  localparam int unsigned OFS_GFEAT    = 'h0C;
  localparam int unsigned OFS_DESC_LO  = 'h20;
  localparam int unsigned OFS_DESC_HI  = 'h24;
  localparam int unsigned OFS_AVAIL_LO = 'h28;
  localparam int unsigned OFS_AVAIL_HI = 'h2C;
  localparam int unsigned OFS_USED_LO  = 'h30;
  localparam int unsigned OFS_USED_HI  = 'h34;

  // merge a write into a 64-bit ring address
  function automatic logic [63:0] merge_addr(input wop_e op,
                                             input logic [63:0] cur,
                                             input logic [63:0] wd);
    logic [63:0] nxt;
    nxt = cur;
    case (op)
      OP_ADDR_LO:   nxt = {cur[63:32], wd[31:0]};
      OP_ADDR_HI:   nxt = {wd[31:0], cur[31:0]};
      OP_ADDR_FULL: nxt = wd;
      default:      nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/vq_decode.sv
module vq_decode
  import vq_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             valid,
  input  logic             write,
  input  logic [OFS_W-1:0] offset,
  input  logic [3:0]       size,
  output wop_e             wop,
  output ring_e            ring,
  output rop_e             rop
);

  always_comb begin
    wop  = OP_NONE;
    ring = RING_NONE;
    rop  = RD_ZERO;
    if (valid && write) begin
      case (size)
        4'd1: begin
          if (offset == OFS_W'(OFS_STATUS)) wop = OP_STATUS;
          else                              wop = OP_BAD;
        end
        4'd2: begin
          case (offset)
            OFS_W'(OFS_MSIX):  wop = OP_MSIX;
            OFS_W'(OFS_QSEL):  wop = OP_QSEL;
            OFS_W'(OFS_QSIZE): wop = OP_QSIZE;
            OFS_W'(OFS_QVEC):  wop = OP_QVEC;
            OFS_W'(OFS_QEN):   wop = OP_QEN;
            default:           wop = OP_BAD;
          endcase
        end
        4'd4: begin
          case (offset)
            OFS_W'(OFS_DFSEL):    wop = OP_DFSEL;
            OFS_W'(OFS_GFSEL):    wop = OP_GFSEL;
            OFS_W'(OFS_GFEAT):    wop = OP_GFEAT;
            OFS_W'(OFS_DESC_LO):  begin wop = OP_ADDR_LO; ring = RING_DESC;  end
            OFS_W'(OFS_DESC_HI):  begin wop = OP_ADDR_HI; ring = RING_DESC;  end
            OFS_W'(OFS_AVAIL_LO): begin wop = OP_ADDR_LO; ring = RING_AVAIL; end
            OFS_W'(OFS_AVAIL_HI): begin wop = OP_ADDR_HI; ring = RING_AVAIL; end
            OFS_W'(OFS_USED_LO):  begin wop = OP_ADDR_LO; ring = RING_USED;  end
            OFS_W'(OFS_USED_HI):  begin wop = OP_ADDR_HI; ring = RING_USED;  end
            default:              wop = OP_BAD;
          endcase
        end
        4'd8: begin
          case (offset)
            OFS_W'(OFS_DESC_LO):  begin wop = OP_ADDR_FULL; ring = RING_DESC;  end
            OFS_W'(OFS_AVAIL_LO): begin wop = OP_ADDR_FULL; ring = RING_AVAIL; end
            OFS_W'(OFS_USED_LO):  begin wop = OP_ADDR_FULL; ring = RING_USED;  end
            default:              wop = OP_BAD;
          endcase
        end
        default: wop = OP_NONE;
      endcase
    end else if (valid && !write) begin
      case (size)
        4'd1: begin
          case (offset)
            OFS_W'(OFS_STATUS): rop = RD_STATUS;
            OFS_W'(OFS_GEN):    rop = RD_GEN;
            default:            rop = RD_ZERO;
          endcase
        end
        4'd2: begin
          case (offset)
            OFS_W'(OFS_MSIX):    rop = RD_MSIX;
            OFS_W'(OFS_NQ):      rop = RD_NQ;
            OFS_W'(OFS_QSEL):    rop = RD_QSEL;
            OFS_W'(OFS_QSIZE):   rop = RD_QSIZE;
            OFS_W'(OFS_QVEC):    rop = RD_QVEC;
            OFS_W'(OFS_QEN):     rop = RD_QEN;
            OFS_W'(OFS_QNOTIFY): rop = RD_QSEL;
            default:             rop = RD_ZERO;
          endcase
        end
        4'd4: begin
          case (offset)
            OFS_W'(OFS_DFSEL): rop = RD_DFSEL;
            OFS_W'(OFS_DFEAT): rop = RD_DFEAT;
            OFS_W'(OFS_GFSEL): rop = RD_GFSEL;
            default:           rop = RD_ZERO;
          endcase
        end
        default: rop = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/vq_dev_regs.sv
module vq_dev_regs
  import vq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  wop_e        wop,
  input  logic [63:0] wdata,
  output logic [7:0]  status,
  output logic [7:0]  cfg_gen,
  output logic [15:0] msix_cfg,
  output logic [15:0] qsel,
  output logic [31:0] dfsel,
  output logic [31:0] gfsel,
  output logic        ack_valid,
  output logic [63:0] ack_mask
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      msix_cfg <= '0;
      qsel     <= '0;
      dfsel    <= '0;
      gfsel    <= '0;
    end else begin
      case (wop)
        OP_STATUS: status   <= wdata[7:0];
        OP_MSIX:   msix_cfg <= wdata[15:0];
        OP_QSEL:   qsel     <= wdata[15:0];
        OP_DFSEL:  dfsel    <= wdata[31:0];
        OP_GFSEL:  gfsel    <= wdata[31:0];
        default:   ;
      endcase
    end
  end

  // generation count: read-only to the driver, nothing in scope advances it
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_gen <= '0;
    else        cfg_gen <= cfg_gen;
  end

  // acknowledge strobe leaves in the cycle of the accepted write
  always_comb begin
    ack_valid = (wop == OP_GFEAT) && (gfsel < 32'd2);
    ack_mask  = '0;
    if (ack_valid) begin
      if (gfsel[0]) ack_mask = {wdata[31:0], 32'h0};
      else          ack_mask = {32'h0, wdata[31:0]};
    end
  end

endmodule

// File: rtl/vq_queue_array.sv
module vq_queue_array
  import vq_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int QMAX = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wop_e           wop,
  input  ring_e          ring,
  input  logic [63:0]    wdata,
  input  logic [15:0]    qsel,
  output logic [NQ-1:0]  q_ready,
  output logic [NQ*16-1:0] q_size,
  output logic [NQ*16-1:0] q_vector,
  output logic [NQ*64-1:0] q_desc,
  output logic [NQ*64-1:0] q_avail,
  output logic [NQ*64-1:0] q_used,
  output logic [15:0]    sel_size,
  output logic [15:0]    sel_vector,
  output logic           sel_ready
);

  localparam logic [15:0] QMAX16 = 16'(QMAX);

  logic [15:0] size_in;
  assign size_in = (wdata[15:0] > QMAX16) ? QMAX16 : wdata[15:0];

  for (genvar i = 0; i < NQ; i++) begin : g_slot
    logic        hit;
    logic        rdy_r;
    logic [15:0] size_r;
    logic [15:0] vec_r;
    logic [63:0] desc_r;
    logic [63:0] avail_r;
    logic [63:0] used_r;

    assign hit = (qsel == 16'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_r   <= 1'b0;
        size_r  <= '0;
        vec_r   <= '0;
        desc_r  <= '0;
        avail_r <= '0;
        used_r  <= '0;
      end else if (hit) begin
        case (wop)
          OP_QSIZE: size_r <= size_in;
          OP_QVEC:  vec_r  <= wdata[15:0];
          OP_QEN:   rdy_r  <= (wdata[15:0] == 16'd1);
          OP_ADDR_LO, OP_ADDR_HI, OP_ADDR_FULL: begin
            case (ring)
              RING_DESC:  desc_r  <= merge_addr(wop, desc_r, wdata);
              RING_AVAIL: avail_r <= merge_addr(wop, avail_r, wdata);
              RING_USED:  used_r  <= merge_addr(wop, used_r, wdata);
              default:    ;
            endcase
          end
          default: ;
        endcase
      end
    end

    assign q_ready[i]           = rdy_r;
    assign q_size[i*16 +: 16]   = size_r;
    assign q_vector[i*16 +: 16] = vec_r;
    assign q_desc[i*64 +: 64]   = desc_r;
    assign q_avail[i*64 +: 64]  = avail_r;
    assign q_used[i*64 +: 64]   = used_r;
  end

  // window onto the selected slot, zero when the selector is out of range
  always_comb begin
    sel_size   = '0;
    sel_vector = '0;
    sel_ready  = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (qsel == 16'(i)) begin
        sel_size   = q_size[i*16 +: 16];
        sel_vector = q_vector[i*16 +: 16];
        sel_ready  = q_ready[i];
      end
    end
  end

endmodule

// File: rtl/vq_common_regs.sv
module vq_common_regs
  import vq_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int QMAX  = 256,
  parameter int OFS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [OFS_W-1:0]   req_offset,
  input  logic [3:0]         req_size,
  input  logic [63:0]        req_wdata,
  output logic               rsp_valid,
  output logic [63:0]        rsp_rdata,
  output logic               wr_err,
  input  logic [63:0]        dev_features,
  output logic               ack_valid,
  output logic [63:0]        ack_mask,
  output logic [NQ-1:0]      q_ready,
  output logic [NQ*16-1:0]   q_size_o,
  output logic [NQ*16-1:0]   q_vector_o,
  output logic [NQ*64-1:0]   q_desc_o,
  output logic [NQ*64-1:0]   q_avail_o,
  output logic [NQ*64-1:0]   q_used_o
);

  localparam logic [15:0] NQ16 = 16'(NQ);

  wop_e  wop;
  ring_e ring;
  rop_e  rop;

  logic [7:0]  status;
  logic [7:0]  cfg_gen;
  logic [15:0] msix_cfg;
  logic [15:0] qsel;
  logic [31:0] dfsel;
  logic [31:0] gfsel;
  logic [15:0] sel_size;
  logic [15:0] sel_vector;
  logic        sel_ready;
  logic [63:0] rd_next;

  vq_decode #(.OFS_W(OFS_W)) u_decode (
    .valid  (req_valid),
    .write  (req_write),
    .offset (req_offset),
    .size   (req_size),
    .wop    (wop),
    .ring   (ring),
    .rop    (rop)
  );

  vq_dev_regs u_dev (
    .clk       (clk),
    .rst_n     (rst_n),
    .wop       (wop),
    .wdata     (req_wdata),
    .status    (status),
    .cfg_gen   (cfg_gen),
    .msix_cfg  (msix_cfg),
    .qsel      (qsel),
    .dfsel     (dfsel),
    .gfsel     (gfsel),
    .ack_valid (ack_valid),
    .ack_mask  (ack_mask)
  );

  vq_queue_array #(.NQ(NQ), .QMAX(QMAX)) u_queues (
    .clk        (clk),
    .rst_n      (rst_n),
    .wop        (wop),
    .ring       (ring),
    .wdata      (req_wdata),
    .qsel       (qsel),
    .q_ready    (q_ready),
    .q_size     (q_size_o),
    .q_vector   (q_vector_o),
    .q_desc     (q_desc_o),
    .q_avail    (q_avail_o),
    .q_used     (q_used_o),
    .sel_size   (sel_size),
    .sel_vector (sel_vector),
    .sel_ready  (sel_ready)
  );

  always_comb begin
    rd_next = '0;
    case (rop)
      RD_STATUS: rd_next = 64'(status);
      RD_GEN:    rd_next = 64'(cfg_gen);
      RD_MSIX:   rd_next = 64'(msix_cfg);
      RD_NQ:     rd_next = 64'(NQ16);
      RD_QSEL:   rd_next = 64'(qsel);
      RD_QSIZE:  rd_next = 64'(sel_size);
      RD_QVEC:   rd_next = 64'(sel_vector);
      RD_QEN:    rd_next = 64'(sel_ready);
      RD_DFSEL:  rd_next = 64'(dfsel);
      RD_GFSEL:  rd_next = 64'(gfsel);
      RD_DFEAT: begin
        if (dfsel == 32'd0)      rd_next = {32'h0, dev_features[31:0]};
        else if (dfsel == 32'd1) rd_next = {32'h0, dev_features[63:32]};
        else                     rd_next = '0;
      end
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
      wr_err    <= (wop == OP_BAD);
    end
  end

endmodule

// File: rtl/vq_common_regs_chk.sv
module vq_common_regs_chk #(
  parameter int NQ    = 4,
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [OFS_W-1:0] req_offset,
  input logic [3:0]       req_size,
  input logic             rsp_valid,
  input logic [63:0]      rsp_rdata,
  input logic             wr_err,
  input logic             ack_valid,
  input logic [63:0]      ack_mask,
  input logic [15:0]      qsel,
  input logic [NQ-1:0]    q_ready,
  input logic [NQ*16-1:0] q_size_o
);

  localparam logic [15:0] NQ16 = 16'(NQ);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic rd_req, wr_req, odd_size;
  assign rd_req   = req_valid && !req_write;
  assign wr_req   = req_valid && req_write;
  assign odd_size = !(req_size == 4'd1 || req_size == 4'd2 ||
                      req_size == 4'd4 || req_size == 4'd8);

  a_r13_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rd_req |=> rsp_valid);

  a_r13_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !rd_req |=> !rsp_valid);

  a_r7_ack_source: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ack_valid |-> (wr_req && req_size == 4'd4 && req_offset == OFS_W'('h0C)));

  a_r7_ack_one_page: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ack_valid |-> (ack_mask[63:32] == 32'h0 || ack_mask[31:0] == 32'h0));

  a_r11_err_after_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wr_err |-> $past(wr_req));

  a_r9_qword_read_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_req && req_size == 4'd8) |=> (rsp_rdata == 64'h0));

  a_r10_oob_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (qsel >= NQ16) |=> ($stable(q_ready) && $stable(q_size_o)));

  a_r5_ready_needs_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !wr_req |=> $stable(q_ready));

  a_r12_odd_size_quiet: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_req && odd_size) |=> !wr_err);

endmodule

bind vq_common_regs vq_common_regs_chk #(.NQ(NQ), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_offset (req_offset),
  .req_size   (req_size),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .wr_err     (wr_err),
  .ack_valid  (ack_valid),
  .ack_mask   (ack_mask),
  .qsel       (qsel),
  .q_ready    (q_ready),
  .q_size_o   (q_size_o)
);

// File: tb/test_vq_common_regs.sv
module test_vq_common_regs;

  localparam int NQ    = 4;
  localparam int QMAX  = 256;
  localparam int OFS_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [OFS_W-1:0]  req_offset = '0;
  logic [3:0]        req_size = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              wr_err;
  logic [63:0]       dev_features = 64'h0123_4567_89AB_CDEF;
  logic              ack_valid;
  logic [63:0]       ack_mask;
  logic [NQ-1:0]     q_ready;
  logic [NQ*16-1:0]  q_size_o;
  logic [NQ*16-1:0]  q_vector_o;
  logic [NQ*64-1:0]  q_desc_o;
  logic [NQ*64-1:0]  q_avail_o;
  logic [NQ*64-1:0]  q_used_o;

  always #4 clk = ~clk;

  vq_common_regs #(.NQ(NQ), .QMAX(QMAX), .OFS_W(OFS_W)) i_vq_common_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_err(wr_err),
    .dev_features(dev_features), .ack_valid(ack_valid), .ack_mask(ack_mask),
    .q_ready(q_ready), .q_size_o(q_size_o), .q_vector_o(q_vector_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one response per queued read
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R13 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  task automatic rd(input string tag, input logic [7:0] ofs, input logic [3:0] sz,
                    input logic [63:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = ofs; req_size = sz; req_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input string tag, input logic [7:0] ofs, input logic [3:0] sz,
                    input logic [63:0] data, input bit exp_err = 1'b0,
                    input bit exp_ack = 1'b0, input logic [63:0] exp_mask = '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = ofs; req_size = sz; req_wdata = data;
    #1;
    chk({tag, " ack"}, {63'h0, ack_valid}, {63'h0, exp_ack});
    if (exp_ack) chk({tag, " mask"}, ack_mask, exp_mask);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " err"}, {63'h0, wr_err}, {63'h0, exp_err});
    chk("R13 no response on write", {63'h0, rsp_valid}, 64'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rsp_valid in reset", {63'h0, rsp_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q_ready", 64'(q_ready), 64'h0);
    chk("R1 wr_err", {63'h0, wr_err}, 64'h0);
    chk("R1 ack_valid", {63'h0, ack_valid}, 64'h0);
    chk("R1 q_desc", q_desc_o[63:0], 64'h0);
    rd("R1 status", 8'h14, 4'd1, 64'h0);
    rd("R1 msix", 8'h10, 4'd2, 64'h0);
    rd("R1 qsize", 8'h18, 4'd2, 64'h0);
    rd("R3 queue count", 8'h12, 4'd2, 64'd4);

    // R2 byte registers
    wr("R2 status write", 8'h14, 4'd1, 64'hA5);
    rd("R2 status read", 8'h14, 4'd1, 64'hA5);
    wr("R2 gen write", 8'h15, 4'd1, 64'h33, 1'b1);
    rd("R2 gen read", 8'h15, 4'd1, 64'h0);

    // R3 word device registers
    wr("R3 msix write", 8'h10, 4'd2, 64'hBEEF);
    rd("R3 msix read", 8'h10, 4'd2, 64'hBEEF);
    wr("R3 qsel write", 8'h16, 4'd2, 64'd2);
    rd("R3 qsel read", 8'h16, 4'd2, 64'd2);
    rd("R3 notify read", 8'h1E, 4'd2, 64'd2);
    wr("R3 count write", 8'h12, 4'd2, 64'd7, 1'b1);
    rd("R3 count kept", 8'h12, 4'd2, 64'd4);
    wr("R3 notify write", 8'h1E, 4'd2, 64'd1, 1'b1);
    rd("R3 qsel kept", 8'h16, 4'd2, 64'd2);

    // R4 size and vector of queue 2
    wr("R4 size write", 8'h18, 4'd2, 64'd64);
    rd("R4 size read", 8'h18, 4'd2, 64'd64);
    chk("R4 size port", 64'(q_size_o[2*16 +: 16]), 64'd64);
    chk("R4 other slot", 64'(q_size_o[1*16 +: 16]), 64'd0);
    wr("R4 size clamp", 8'h18, 4'd2, 64'd1000);
    rd("R4 size clamped", 8'h18, 4'd2, 64'd256);
    wr("R4 vector write", 8'h1A, 4'd2, 64'h0077);
    rd("R4 vector read", 8'h1A, 4'd2, 64'h0077);
    chk("R4 vector port", 64'(q_vector_o[2*16 +: 16]), 64'h77);

    // R5 enable
    wr("R5 enable one", 8'h1C, 4'd2, 64'd1);
    chk("R5 ready port", 64'(q_ready), 64'b0100);
    rd("R5 enable read", 8'h1C, 4'd2, 64'd1);
    wr("R5 enable three", 8'h1C, 4'd2, 64'd3);
    chk("R5 cleared by 3", 64'(q_ready), 64'b0000);
    rd("R5 enable read 0", 8'h1C, 4'd2, 64'd0);
    wr("R5 enable again", 8'h1C, 4'd2, 64'd1);
    wr("R5 enable zero", 8'h1C, 4'd2, 64'd0);
    chk("R5 cleared by 0", 64'(q_ready), 64'b0000);

    // R6 device feature pages
    rd("R6 page0", 8'h04, 4'd4, 64'h89AB_CDEF);
    wr("R6 dfsel write", 8'h00, 4'd4, 64'd1);
    rd("R6 dfsel read", 8'h00, 4'd4, 64'd1);
    rd("R6 page1", 8'h04, 4'd4, 64'h0123_4567);
    wr("R6 dfsel two", 8'h00, 4'd4, 64'd2);
    rd("R6 page2 zero", 8'h04, 4'd4, 64'h0);
    wr("R6 feature write", 8'h04, 4'd4, 64'h1, 1'b1);

    // R7 driver feature acknowledge
    wr("R7 ack page0", 8'h0C, 4'd4, 64'hF0F0, 1'b0, 1'b1, 64'h0000_0000_0000_F0F0);
    wr("R7 gfsel write", 8'h08, 4'd4, 64'd1);
    rd("R7 gfsel read", 8'h08, 4'd4, 64'd1);
    wr("R7 ack page1", 8'h0C, 4'd4, 64'hFFFF_FFFF_0000_00AB, 1'b0, 1'b1, 64'h0000_00AB_0000_0000);
    wr("R7 gfsel five", 8'h08, 4'd4, 64'd5);
    wr("R7 ack dropped", 8'h0C, 4'd4, 64'h1234);
    rd("R7 driver feature reads zero", 8'h0C, 4'd4, 64'h0);

    // R8 half writes on queue 2
    wr("R8 desc lo", 8'h20, 4'd4, 64'h1111_2222);
    chk("R8 desc after lo", q_desc_o[2*64 +: 64], 64'h0000_0000_1111_2222);
    wr("R8 desc hi", 8'h24, 4'd4, 64'h3333_4444);
    chk("R8 desc after hi", q_desc_o[2*64 +: 64], 64'h3333_4444_1111_2222);
    wr("R8 desc lo again", 8'h20, 4'd4, 64'h5555);
    chk("R8 desc hi kept", q_desc_o[2*64 +: 64], 64'h3333_4444_0000_5555);
    wr("R8 avail hi", 8'h2C, 4'd4, 64'hAAAA_0001);
    chk("R8 avail", q_avail_o[2*64 +: 64], 64'hAAAA_0001_0000_0000);
    wr("R8 used lo", 8'h30, 4'd4, 64'h0BAD_F00D);
    wr("R8 used hi", 8'h34, 4'd4, 64'h0000_0007);
    chk("R8 used", q_used_o[2*64 +: 64], 64'h0000_0007_0BAD_F00D);
    chk("R8 other slot untouched", q_desc_o[0 +: 64], 64'h0);

    // R9 full writes and qword reads
    wr("R9 avail full", 8'h28, 4'd8, 64'hFEDC_BA98_7654_3210);
    chk("R9 avail full port", q_avail_o[2*64 +: 64], 64'hFEDC_BA98_7654_3210);
    wr("R9 desc full", 8'h20, 4'd8, 64'h1);
    chk("R9 desc full port", q_desc_o[2*64 +: 64], 64'h1);
    wr("R9 used full", 8'h30, 4'd8, 64'hCAFE_0000_0000_BEEF);
    chk("R9 used full port", q_used_o[2*64 +: 64], 64'hCAFE_0000_0000_BEEF);
    rd("R9 qword read", 8'h20, 4'd8, 64'h0);
    rd("R9 qword read feature", 8'h00, 4'd8, 64'h0);
    wr("R9 qword unmapped", 8'h38, 4'd8, 64'h5, 1'b1);

    // R10 selector out of range
    wr("R10 qsel=NQ", 8'h16, 4'd2, 64'd4);
    rd("R10 size zero", 8'h18, 4'd2, 64'd0);
    rd("R10 vector zero", 8'h1A, 4'd2, 64'd0);
    wr("R10 size write", 8'h18, 4'd2, 64'd8);
    wr("R10 enable write", 8'h1C, 4'd2, 64'd1);
    wr("R10 desc write", 8'h20, 4'd8, 64'hDEAD);
    chk("R10 ready kept", 64'(q_ready), 64'h0);
    chk("R10 desc kept", q_desc_o[2*64 +: 64], 64'h1);
    chk("R10 sizes kept", 64'(q_size_o), {16'd0, 16'd256, 16'd0, 16'd0});
    rd("R10 qsel read", 8'h16, 4'd2, 64'd4);
    wr("R10 qsel max", 8'h16, 4'd2, 64'hFFFF);
    rd("R10 enable zero", 8'h1C, 4'd2, 64'd0);
    wr("R10 vector write", 8'h1A, 4'd2, 64'h99);
    chk("R10 vectors kept", 64'(q_vector_o), {16'd0, 16'h77, 16'd0, 16'd0});

    // R11 unmapped offsets
    rd("R11 word unmapped", 8'h40, 4'd2, 64'h0);
    rd("R11 dword ring read", 8'h20, 4'd4, 64'h0);
    wr("R11 byte unmapped", 8'h11, 4'd1, 64'h5A, 1'b1);
    rd("R11 status kept", 8'h14, 4'd1, 64'hA5);
    wr("R11 byte at msix", 8'h10, 4'd1, 64'h12, 1'b1);
    rd("R11 msix kept", 8'h10, 4'd2, 64'hBEEF);

    // R12 widths outside the set
    wr("R12 size3 write", 8'h14, 4'd3, 64'h11);
    rd("R12 status kept", 8'h14, 4'd1, 64'hA5);
    rd("R12 size3 read", 8'h14, 4'd3, 64'h0);
    rd("R12 word at byte reg", 8'h14, 4'd2, 64'h0);
    wr("R12 size0 write", 8'h10, 4'd0, 64'h1);
    rd("R12 msix kept", 8'h10, 4'd2, 64'hBEEF);

    // R13 every read answered once
    repeat (3) @(negedge clk);
    chk("R13 all reads answered", 64'(exp_q.size()), 64'h0);
    chk("R13 idle rsp_valid", {63'h0, rsp_valid}, 64'h0);
    summary();
  end

endmodule